// File: doc/BRIEF.md
# Sub-word Register Write Combining Bridge

This bridge connects a host port that issues byte, halfword and word register accesses to an SD host controller register file that only accepts aligned 32-bit accesses. Narrow reads are served from one aligned word read, with the requested field shifted down and zero-extended. Narrow writes become read-modify-write sequences on the aligned word.

Two adjacent halfword writes to one register word can be lost by the controller when they come too close together. To avoid this, halfword writes to the block-size, block-count and transfer-mode fields are kept in two shadow words. The controller does not see them until the command halfword is written. At that point the bridge writes the block word, if it is non-zero, and then the transfer-mode/command word, as two whole 32-bit writes.

Each downstream write is followed by a settling interval whose length depends on the SD clock frequency, which is given to the bridge in hertz. The host sees ready only once the whole sequence for its access has finished. The host keeps one access outstanding at a time and holds its request until ready.

Top module: `sdreg_bridge`

## Requirements
- R1: After synchronous reset, `hst_ready` and `dn_req` are low and both shadow words are zero. A first command halfword write therefore produces a single downstream write.
- R2: A read issues one downstream read at the address with bits [1:0] cleared. The result is the aligned word shifted right by 8 × addr[1:0] and masked to 8 bits (size 0), 16 bits (size 1) or 32 bits (size 2), zero-extended on `hst_rdata`.
- R3: A byte write (size 0) reads the aligned word, replaces only the byte at bit 8 × addr[1:0], and writes the whole word back to the aligned address.
- R4: A halfword write (size 1) to an address other than 0x04, 0x06, 0x0C and 0x0E is a read-modify-write of the 16-bit field at bit 8 × addr[1:0] of the aligned word.
- R5: A halfword write to 0x04 (block size) or 0x06 (block count) causes no downstream access. It is merged into the block shadow at bits [15:0] or [31:16].
- R6: A halfword write to 0x0C (transfer mode) causes no downstream access. It is merged into bits [15:0] of the command shadow.
- R7: On a halfword write to 0x0E (command), a non-zero block shadow is written to address 0x04 first and then cleared to zero. A zero block shadow produces no write.
- R8: The command write then goes to 0x0C, carrying the command shadow with the new halfword in bits [31:16]. The command shadow itself keeps its old value.
- R9: A word write (size 2) goes straight to the aligned address with the host data and leaves both shadows unchanged.
- R10: After each downstream write the bridge waits. The wait is ceil(4 000 000 / f) µs when the SD clock f satisfies 0 < f ≤ 400 kHz, 10 µs when f = 0, and nothing otherwise. The next write or ready comes exactly wait × (SYS_CLK_HZ/1e6) + 2 cycles after the write cycle.
- R11: `hst_ready` is a one-cycle pulse at the end of the sequence, and no downstream request is active in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host access request, held until ready |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_size | input | 2 | 0 byte, 1 halfword, 2 word |
| hst_addr | input | ADDR_W | Byte address of the access |
| hst_wdata | input | 32 | Write data, right-aligned |
| hst_rdata | output | 32 | Read data, valid with ready |
| hst_ready | output | 1 | Access completed (one cycle) |
| sd_clk_hz | input | 32 | Current SD clock frequency in Hz |
| dn_req | output | 1 | Downstream access strobe |
| dn_we | output | 1 | Downstream write enable |
| dn_addr | output | ADDR_W | Downstream word-aligned address |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, valid the cycle after a read strobe |

## Verification
A stale or uncleared block shadow shows up at the next command halfword. It appears either as an extra write to 0x04 or as a wrong word there, so the error stays hidden until a command is issued. A wrong command shadow corrupts the low half of the 0x0C write at the same moment. Lane or mask errors appear at once, in the merged word of the same byte or halfword access or in the returned read field. A miscounted settling timer moves the next downstream write or the ready pulse by whole microseconds, which shows up as a gap of the wrong length measured in cycles.

// File: rtl/sdreg_pkg.sv
package sdreg_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ISSUE,
        ST_RD_CAP,
        ST_WR,
        ST_BLK_WR,
        ST_CMD_WR,
        ST_HOLD,
        ST_DONE
    } br_state_e;

    // Register offsets whose position the shadow logic decodes
    localparam logic [7:0] OFS_BLKSZ  = 8'h04;
    localparam logic [7:0] OFS_BLKCNT = 8'h06;
    localparam logic [7:0] OFS_TMODE  = 8'h0C;
    localparam logic [7:0] OFS_CMD    = 8'h0E;

    function automatic logic [31:0] lane_mask(acc_size_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [4:0] lane_shift(logic [1:0] lo);
        return {lo, 3'b000};
    endfunction

    function automatic logic [31:0] lane_merge(logic [31:0] old, logic [31:0] val,
                                               logic [4:0] sh, acc_size_e sz);
        logic [31:0] m;
        m = lane_mask(sz);
        return (old & ~(m << sh)) | ((val & m) << sh);
    endfunction

    function automatic logic [31:0] lane_extract(logic [31:0] word, logic [4:0] sh,
                                                 acc_size_e sz);
        return (word >> sh) & lane_mask(sz);
    endfunction

    // Settling time in microseconds after one downstream write
    function automatic logic [31:0] settle_us(logic [31:0] hz, int unsigned slow_hz,
                                              int unsigned zero_us, int unsigned periods);
        logic [31:0] num;
        if (hz == 32'd0) return 32'(zero_us);
        if (hz > 32'(slow_hz)) return 32'd0;
        num = 32'(periods) * 32'd1_000_000 + hz - 32'd1;
        return num / hz;
    endfunction

endpackage

// File: rtl/sdreg_holdoff.sv
module sdreg_holdoff
    import sdreg_pkg::*;
#(
    parameter int SYS_CLK_HZ     = 100_000_000,
    parameter int SLOW_HZ        = 400_000,
    parameter int ZERO_CLK_US    = 10,
    parameter int SETTLE_PERIODS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] sd_hz,
    output logic        done
);
    localparam int CYC_PER_US = SYS_CLK_HZ / 1_000_000;
    localparam int PRE_W      = $clog2(CYC_PER_US + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);

    logic [31:0]      us_left;
    logic [PRE_W-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            us_left <= '0;
            pre     <= '0;
        end else if (load) begin
            us_left <= settle_us(sd_hz, SLOW_HZ, ZERO_CLK_US, SETTLE_PERIODS);
            pre     <= '0;
        end else if (us_left != 32'd0) begin
            if (pre == PRE_LAST) begin
                pre     <= '0;
                us_left <= us_left - 32'd1;
            end else begin
                pre <= pre + PRE_W'(1);
            end
        end
    end

    assign done = (us_left == 32'd0);

    AST_HOLD_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && us_left != 32'd0 && pre != PRE_LAST) |=> $stable(us_left)); // R10

    AST_HOLD_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!load && us_left != 32'd0 && pre == PRE_LAST) |=> (us_left == $past(us_left) - 32'd1)); // R10

endmodule

// File: rtl/sdreg_shadows.sv
module sdreg_shadows
    import sdreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        blk_we,
    input  logic        blk_clr,
    input  logic        cmd_we,
    input  logic [4:0]  sh,
    input  logic [15:0] half,
    output logic [31:0] blk_q,
    output logic [31:0] cmd_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q <= '0;
            cmd_q <= '0;
        end else begin
            if (blk_clr)
                blk_q <= '0;
            else if (blk_we)
                blk_q <= lane_merge(blk_q, {16'd0, half}, sh, SZ_HALF);
            if (cmd_we)
                cmd_q <= lane_merge(cmd_q, {16'd0, half}, sh, SZ_HALF);
        end
    end

    AST_BLK_CLEARED: assert property (@(posedge clk) disable iff (rst)
        blk_clr |=> (blk_q == 32'd0)); // R7

    AST_CMD_KEPT: assert property (@(posedge clk) disable iff (rst)
        !cmd_we |=> $stable(cmd_q)); // R8

    AST_BLK_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!blk_we && !blk_clr) |=> $stable(blk_q)); // R9

endmodule

// File: rtl/sdreg_bridge.sv
module sdreg_bridge
    import sdreg_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int SYS_CLK_HZ     = 100_000_000,
    parameter int SLOW_HZ        = 400_000,
    parameter int ZERO_CLK_US    = 10,
    parameter int SETTLE_PERIODS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_req,
    input  logic              hst_we,
    input  logic [1:0]        hst_size,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [31:0]       hst_wdata,
    output logic [31:0]       hst_rdata,
    output logic              hst_ready,
    input  logic [31:0]       sd_clk_hz,
    output logic              dn_req,
    output logic              dn_we,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [31:0]       dn_wdata,
    input  logic [31:0]       dn_rdata
);
    localparam logic [ADDR_W-1:0] A_BLKSZ  = ADDR_W'(OFS_BLKSZ);
    localparam logic [ADDR_W-1:0] A_BLKCNT = ADDR_W'(OFS_BLKCNT);
    localparam logic [ADDR_W-1:0] A_TMODE  = ADDR_W'(OFS_TMODE);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);

    typedef struct packed {
        logic              we;
        acc_size_e         size;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
    } host_req_t;

    br_state_e   st, ret_st;
    host_req_t   rq;
    logic [31:0] wword, rdata_q;
    logic [31:0] blk_sh, cmd_sh;
    logic        blk_we, blk_clr, cmd_we;
    logic        hold_load, hold_done;
    logic        in_half_wr;
    acc_size_e   in_size;
    logic [4:0]  rq_sh;
    logic [ADDR_W-1:0] rq_aligned;

    assign in_size    = acc_size_e'(hst_size);
    assign in_half_wr = (st == ST_IDLE) && hst_req && hst_we && (in_size == SZ_HALF);
    assign blk_we     = in_half_wr && (hst_addr == A_BLKSZ || hst_addr == A_BLKCNT);
    assign cmd_we     = in_half_wr && (hst_addr == A_TMODE);
    assign blk_clr    = (st == ST_BLK_WR);
    assign rq_sh      = lane_shift(rq.addr[1:0]);
    assign rq_aligned = {rq.addr[ADDR_W-1:2], 2'b00};

    sdreg_shadows u_shadows (
        .clk     (clk),
        .rst     (rst),
        .blk_we  (blk_we),
        .blk_clr (blk_clr),
        .cmd_we  (cmd_we),
        .sh      (lane_shift(hst_addr[1:0])),
        .half    (hst_wdata[15:0]),
        .blk_q   (blk_sh),
        .cmd_q   (cmd_sh)
    );

    sdreg_holdoff #(
        .SYS_CLK_HZ     (SYS_CLK_HZ),
        .SLOW_HZ        (SLOW_HZ),
        .ZERO_CLK_US    (ZERO_CLK_US),
        .SETTLE_PERIODS (SETTLE_PERIODS)
    ) u_holdoff (
        .clk   (clk),
        .rst   (rst),
        .load  (hold_load),
        .sd_hz (sd_clk_hz),
        .done  (hold_done)
    );

    // Downstream drive
    always_comb begin
        dn_req   = 1'b0;
        dn_we    = 1'b0;
        dn_addr  = '0;
        dn_wdata = '0;
        case (st)
            ST_RD_ISSUE: begin
                dn_req  = 1'b1;
                dn_addr = rq_aligned;
            end
            ST_WR: begin
                dn_req   = 1'b1;
                dn_we    = 1'b1;
                dn_addr  = rq_aligned;
                dn_wdata = wword;
            end
            ST_BLK_WR: begin
                dn_req   = 1'b1;
                dn_we    = 1'b1;
                dn_addr  = A_BLKSZ;
                dn_wdata = blk_sh;
            end
            ST_CMD_WR: begin
                dn_req   = 1'b1;
                dn_we    = 1'b1;
                dn_addr  = A_TMODE;
                dn_wdata = lane_merge(cmd_sh, rq.data, 5'd16, SZ_HALF);
            end
            default: ;
        endcase
    end

    assign hold_load = dn_req && dn_we;
    assign hst_ready = (st == ST_DONE);
    assign hst_rdata = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ret_st  <= ST_DONE;
            rq      <= '0;
            wword   <= '0;
            rdata_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (hst_req) begin
                    rq <= '{we: hst_we, size: in_size, addr: hst_addr, data: hst_wdata};
                    if (!hst_we)
                        st <= ST_RD_ISSUE;
                    else if (in_size == SZ_WORD) begin
                        wword <= hst_wdata;
                        st    <= ST_WR;
                    end else if (blk_we || cmd_we)
                        st <= ST_DONE;
                    else if (in_size == SZ_HALF && hst_addr == A_CMD)
                        st <= (blk_sh != 32'd0) ? ST_BLK_WR : ST_CMD_WR;
                    else
                        st <= ST_RD_ISSUE;
                end
                ST_RD_ISSUE: st <= ST_RD_CAP;
                ST_RD_CAP: begin
                    if (!rq.we) begin
                        rdata_q <= lane_extract(dn_rdata, rq_sh, rq.size);
                        st      <= ST_DONE;
                    end else begin
                        wword <= lane_merge(dn_rdata, rq.data, rq_sh, rq.size);
                        st    <= ST_WR;
                    end
                end
                ST_WR: begin
                    ret_st <= ST_DONE;
                    st     <= ST_HOLD;
                end
                ST_BLK_WR: begin
                    ret_st <= ST_CMD_WR;
                    st     <= ST_HOLD;
                end
                ST_CMD_WR: begin
                    ret_st <= ST_DONE;
                    st     <= ST_HOLD;
                end
                ST_HOLD: if (hold_done) st <= ret_st;
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        hst_ready |=> !hst_ready); // R11

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        hst_ready |-> !dn_req); // R11

    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (rst)
        !hold_done |-> !dn_req); // R10

    AST_BLK_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (dn_req && dn_we && dn_addr == A_BLKSZ && st == ST_BLK_WR) |-> (dn_wdata != 32'd0)); // R7

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        dn_req |-> (dn_addr[1:0] == 2'b00)); // R2

endmodule

// File: tb/test_sdreg_bridge.sv
module test_sdreg_bridge;

    logic        clk = 1'b0;
    logic        rst;
    logic        hst_req, hst_we;
    logic [1:0]  hst_size;
    logic [7:0]  hst_addr;
    logic [31:0] hst_wdata, hst_rdata;
    logic        hst_ready;
    logic [31:0] sd_clk_hz;
    logic        dn_req, dn_we;
    logic [7:0]  dn_addr;
    logic [31:0] dn_wdata;
    logic [31:0] dn_rdata;

    always #5 clk = ~clk;

    sdreg_bridge i_sdreg_bridge (
        .clk(clk), .rst(rst),
        .hst_req(hst_req), .hst_we(hst_we), .hst_size(hst_size), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_ready(hst_ready),
        .sd_clk_hz(sd_clk_hz),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr),
        .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
    );

    // Downstream register file model
    logic [31:0] mem [0:63];
    always @(posedge clk) begin
        if (dn_req && dn_we) mem[dn_addr[7:2]] <= dn_wdata;
        if (dn_req && !dn_we) dn_rdata <= mem[dn_addr[7:2]];
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Observed downstream writes
    logic [7:0]  obs_a[$];
    logic [31:0] obs_d[$];
    int          obs_c[$];
    always @(negedge clk) begin
        if (!rst && dn_req && dn_we) begin
            obs_a.push_back(dn_addr);
            obs_d.push_back(dn_wdata);
            obs_c.push_back(cyc);
        end
    end

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Reference model state
    logic [31:0] ref_mem [0:63];
    logic [31:0] ref_blk, ref_cmd;
    logic [7:0]  exp_a[$];
    logic [31:0] exp_d[$];

    function automatic logic [31:0] msk(input logic [1:0] sz);
        if (sz == 2'd0) return 32'hFF;
        if (sz == 2'd1) return 32'hFFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic int settle_expect(input logic [31:0] hz);
        if (hz == 0) return 10;
        if (hz <= 400000) return int'((64'd4000000 + 64'(hz) - 1) / 64'(hz));
        return 0;
    endfunction

    task automatic ref_push(input logic [7:0] a, input logic [31:0] d);
        exp_a.push_back(a);
        exp_d.push_back(d);
        ref_mem[a[7:2]] = d;
    endtask

    task automatic ref_access(input logic we, input logic [1:0] sz, input logic [7:0] a,
                              input logic [31:0] d, output logic [31:0] rd);
        int sh;
        logic [31:0] m, base;
        sh = int'(a[1:0]) * 8;
        m  = msk(sz);
        rd = 32'd0;
        base = ref_mem[a[7:2]];
        if (!we) begin
            rd = (base >> sh) & m;
        end else if (sz == 2'd2) begin
            ref_push({a[7:2], 2'b00}, d);
        end else if (sz == 2'd1 && (a == 8'h04 || a == 8'h06)) begin
            ref_blk = (ref_blk & ~(m << sh)) | ((d & m) << sh);
        end else if (sz == 2'd1 && a == 8'h0C) begin
            ref_cmd = (ref_cmd & ~m) | (d & m);
        end else if (sz == 2'd1 && a == 8'h0E) begin
            if (ref_blk != 0) begin
                ref_push(8'h04, ref_blk);
                ref_blk = 32'd0;
            end
            ref_push(8'h0C, {d[15:0], ref_cmd[15:0]});
        end else begin
            ref_push({a[7:2], 2'b00}, (base & ~(m << sh)) | ((d & m) << sh));
        end
    endtask

    task automatic run(input logic we, input logic [1:0] sz, input logic [7:0] a,
                       input logic [31:0] d, input string tag);
        logic [31:0] exp_rd, act_rd;
        int rdy_c, gap, n;
        ref_access(we, sz, a, d, exp_rd);
        @(negedge clk);
        hst_req = 1'b1; hst_we = we; hst_size = sz; hst_addr = a; hst_wdata = d;
        do @(negedge clk); while (!hst_ready);
        act_rd = hst_rdata;
        rdy_c  = cyc;
        hst_req = 1'b0;
        @(negedge clk);
        chk(hst_ready == 1'b0, "R11 ready one cycle", 32'(hst_ready), 32'd0);
        if (!we) chk(act_rd == exp_rd, {tag, " read data"}, act_rd, exp_rd);
        chk(obs_a.size() == exp_a.size(), {tag, " write count"}, 32'(obs_a.size()), 32'(exp_a.size()));
        n = settle_expect(sd_clk_hz) * 100 + 2;
        for (int i = 0; i < exp_a.size() && i < obs_a.size(); i++) begin
            chk(obs_a[i] == exp_a[i], {tag, " write addr"}, 32'(obs_a[i]), 32'(exp_a[i]));
            chk(obs_d[i] == exp_d[i], {tag, " write data"}, obs_d[i], exp_d[i]);
            gap = ((i + 1 < obs_c.size()) ? obs_c[i + 1] : rdy_c) - obs_c[i];
            chk(gap == n, "R10 settle gap", 32'(gap), 32'(n));
        end
        obs_a.delete(); obs_d.delete(); obs_c.delete();
        exp_a.delete(); exp_d.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R11 act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i] = 32'd0;
            ref_mem[i] = 32'd0;
        end
        ref_blk = 32'd0; ref_cmd = 32'd0;
        rst = 1'b1; hst_req = 1'b0; hst_we = 1'b0; hst_size = 2'd0;
        hst_addr = 8'd0; hst_wdata = 32'd0; sd_clk_hz = 32'd25_000_000;
        repeat (3) @(negedge clk);
        chk(hst_ready == 1'b0, "R1 reset ready", 32'(hst_ready), 32'd0);
        chk(dn_req == 1'b0, "R1 reset dn_req", 32'(dn_req), 32'd0);
        rst = 1'b0;

        run(1'b1, 2'd1, 8'h0E, 32'h0011, "R1 empty shadows R8 command");
        run(1'b1, 2'd2, 8'h20, 32'hA1B2_C3D4, "R9 word write");
        run(1'b0, 2'd1, 8'h22, 32'd0, "R2 half read");
        run(1'b0, 2'd0, 8'h21, 32'd0, "R2 byte read");
        run(1'b0, 2'd2, 8'h20, 32'd0, "R2 word read");
        run(1'b1, 2'd0, 8'h23, 32'h5A, "R3 byte write");
        run(1'b1, 2'd0, 8'h20, 32'hFFFF_FF07, "R3 byte write low lane");
        run(1'b1, 2'd1, 8'h22, 32'h1234, "R4 half write");
        run(1'b0, 2'd2, 8'h20, 32'd0, "R4 readback");
        run(1'b1, 2'd1, 8'h04, 32'h0200, "R5 block size");
        run(1'b1, 2'd1, 8'h06, 32'h0003, "R5 block count");
        run(1'b1, 2'd1, 8'h0C, 32'h0025, "R6 transfer mode");
        run(1'b1, 2'd2, 8'h04, 32'hFFFF_FFFF, "R9 word write keeps shadows");
        run(1'b1, 2'd1, 8'h0E, 32'h113A, "R7 block then command");
        run(1'b1, 2'd1, 8'h0E, 32'h0C1B, "R7 cleared R8 kept");
        run(1'b0, 2'd2, 8'h04, 32'd0, "R7 block word readback");

        sd_clk_hz = 32'd400_000;
        run(1'b1, 2'd2, 8'h30, 32'h0000_0001, "R10 at 400 kHz");
        sd_clk_hz = 32'd0;
        run(1'b1, 2'd2, 8'h30, 32'h0000_0002, "R10 stopped clock");
        sd_clk_hz = 32'd150_000;
        run(1'b1, 2'd0, 8'h31, 32'h0000_0077, "R10 150 kHz rmw");
        sd_clk_hz = 32'd400_001;
        run(1'b1, 2'd2, 8'h30, 32'h0000_0003, "R10 just above limit");
        sd_clk_hz = 32'd300_000;
        run(1'b1, 2'd1, 8'h06, 32'h0001, "R5 slow count");
        run(1'b1, 2'd1, 8'h0E, 32'h0A00, "R10 slow block and command");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule